// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a calendar that is kept elsewhere and raises an alarm interrupt when the time reaches a programmed value. The calendar supplies six BCD time fields: seconds, minutes, hours, day of month, month, and a three-digit year. It also supplies a one-cycle strobe right after each one-second advance. On every strobe the block compares each time field with its own alarm field. Each comparison has its own enable bit, and a global arm bit gates all of them.

The enabled comparisons are combined with OR, so any single enabled field that matches fires the alarm. A fire sets a sticky pending flag, and the interrupt output follows that flag. Software clears the flag by writing a one to its bit. A small register port holds the control word, the six alarm fields and the pending flag. Each alarm field keeps only as many bits as its BCD range needs.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the control word, all six alarm fields and the pending flag read as zero, and `alarm_irq` is low.
- R2: The control word is at address 0 and keeps bits [6:0]. Bits 0 to 5 enable the seconds, minutes, hours, day, month and year comparisons, in that order. Bit 6 arms the alarm.
- R3: Each alarm field is masked on write and reads back masked. The seconds field is at address 1 and the minutes field at address 2; both keep 7 bits. The hours field is at address 3 and the day field at address 4; both keep 6 bits. The month field is at address 5 and keeps 5 bits. The year field is at address 6 and keeps 12 bits.
- R4: With control bit 6 clear, no strobe sets the pending flag, whatever the fields hold.
- R5: With bit 6 set, a strobe fires the alarm when at least one enabled field equals its time field. A matching field whose enable bit is clear does not fire.
- R6: The year comparison covers all three BCD digits. Bits [7:0] hold the tens and units and bits [11:8] hold the hundreds.
- R7: Comparisons happen only in a cycle where `sec_tick` is high. Matching time without the strobe never fires.
- R8: A fire sets pending bit 1, read at address 7, on the clock edge that samples the strobe. `alarm_irq` is high from that edge on.
- R9: The pending flag stays set until a write to address 7 with data bit 1 set clears it and drops `alarm_irq`. A write to address 7 with bit 1 clear has no effect.
- R10: When a fire and a clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe after each second advance |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| alarm_irq | output | 1 | Alarm interrupt, level, equal to the pending flag |

## Verification
A wrong alarm field or enable bit shows on the very next strobe. `alarm_irq` is then high one edge later than it should stay low, or stays low where it should rise. A bad masking shows at once on read-back of the field. A pending flag that is lost or stuck shows on `alarm_irq` and on address 7 in the cycle after the clear write or the fire. The vectors drive one field at a time against fixed alarm values, so a fault in one field's lane or enable bit is isolated to the failing vector.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFIELD  = 6;
  localparam int FLD_W   = 12;
  localparam int CTRL_W  = NFIELD + 1;
  localparam int ARM_BIT = NFIELD;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;
  localparam int PEND_BIT = 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd7;

  // stored width of field i: sec, min, hour, day, month, year
  function automatic int fld_width(input int i);
    case (i)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 12;
    endcase
  endfunction

  function automatic logic [FLD_W-1:0] fld_mask(input int i);
    return FLD_W'((1 << fld_width(i)) - 1);
  endfunction

  // address of field i is one above the control word
  function automatic logic [ADDR_W-1:0] fld_addr(input int i);
    return ADDR_W'(i + 1);
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pend,
  output logic [DATA_W-1:0] rdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [FLD_W-1:0]  alm_fld [NFIELD],
  output logic              clr_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ctrl <= '0;
    else if (wr && addr == A_CTRL) ctrl <= wdata[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         alm_fld[i] <= '0;
      else if (wr && addr == fld_addr(i)) alm_fld[i] <= wdata[FLD_W-1:0] & fld_mask(i);
    end
    // R3: stored field never has bits above its width
    AST_FIELD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_fld[i] & ~fld_mask(i)) == '0); // R3
  end

  assign clr_req = wr && (addr == A_PEND) && wdata[PEND_BIT];

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)      rdata[CTRL_W-1:0] = ctrl;
    else if (addr == A_PEND) rdata[PEND_BIT]   = pend;
    else begin
      for (int i = 0; i < NFIELD; i++)
        if (addr == fld_addr(i)) rdata[FLD_W-1:0] = alm_fld[i];
    end
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import cal_alarm_pkg::*;
(
  input  logic              tick,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [FLD_W-1:0]  alm_fld [NFIELD],
  input  logic [FLD_W-1:0]  cur_fld [NFIELD],
  output logic [NFIELD-1:0] hit,
  output logic              fire
);
  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign hit[i] = ctrl[i] && (alm_fld[i] == cur_fld[i]);
  end

  assign fire = tick && ctrl[ARM_BIT] && (|hit);
endmodule

// File: rtl/alarm_pending.sv
module alarm_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (fire) pend <= 1'b1;
    else if (clr)  pend <= 1'b0;
  end

  AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pend); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend); // R9
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !pend); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && fire) |=> pend); // R10
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_mday,
  input  logic [7:0]        cur_mon,
  input  logic [11:0]       cur_year,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              alarm_irq
);
  logic [CTRL_W-1:0] ctrl;
  logic [FLD_W-1:0]  alm_fld [NFIELD];
  logic [FLD_W-1:0]  cur_fld [NFIELD];
  logic [NFIELD-1:0] hit;
  logic              fire;
  logic              clr_req;
  logic              pend;

  assign cur_fld[0] = {4'h0, cur_sec};
  assign cur_fld[1] = {4'h0, cur_min};
  assign cur_fld[2] = {4'h0, cur_hour};
  assign cur_fld[3] = {4'h0, cur_mday};
  assign cur_fld[4] = {4'h0, cur_mon};
  assign cur_fld[5] = cur_year;

  alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pend(pend), .rdata(reg_rdata), .ctrl(ctrl), .alm_fld(alm_fld), .clr_req(clr_req)
  );

  alarm_compare u_cmp (
    .tick(sec_tick), .ctrl(ctrl), .alm_fld(alm_fld), .cur_fld(cur_fld),
    .hit(hit), .fire(fire)
  );

  alarm_pending u_pend (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clr(clr_req), .pend(pend)
  );

  assign alarm_irq = pend;

  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(sec_tick)); // R7
  AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(ctrl[ARM_BIT])); // R4
  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(|hit)); // R5
endmodule

// File: tb/sim_cal_alarm_match.sv
module sim_cal_alarm_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic [7:0]  cur_sec = '0, cur_min = '0, cur_hour = '0, cur_mday = '0, cur_mon = '0;
  logic [11:0] cur_year = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        alarm_irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cal_alarm_match u0 (.*);

  // vector: ctrl[6:0], sec, min, hour, day, mon, year[11:0], expected fire
  // alarms programmed to sec 30, min 15, hour 12, day 25, mon 07, year 123
  localparam int NV = 12;
  localparam logic [59:0] VEC [NV] = '{
    {7'h41, 8'h30, 8'h02, 8'h03, 8'h04, 8'h05, 12'h001, 1'b1}, // R5 sec
    {7'h01, 8'h30, 8'h02, 8'h03, 8'h04, 8'h05, 12'h001, 1'b0}, // R4 unarmed
    {7'h7E, 8'h30, 8'h02, 8'h03, 8'h04, 8'h05, 12'h001, 1'b0}, // R5 sec disabled
    {7'h42, 8'h01, 8'h15, 8'h03, 8'h04, 8'h05, 12'h001, 1'b1}, // R5 min
    {7'h44, 8'h01, 8'h02, 8'h12, 8'h04, 8'h05, 12'h001, 1'b1}, // R5 hour
    {7'h48, 8'h01, 8'h02, 8'h03, 8'h25, 8'h05, 12'h001, 1'b1}, // R5 day
    {7'h50, 8'h01, 8'h02, 8'h03, 8'h04, 8'h07, 12'h001, 1'b1}, // R5 month
    {7'h60, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 12'h123, 1'b1}, // R6 year
    {7'h60, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 12'h023, 1'b0}, // R6 hundreds differ
    {7'h60, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 12'h124, 1'b0}, // R6 units differ
    {7'h7F, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 12'h001, 1'b0}, // R5 none match
    {7'h7F, 8'h30, 8'h15, 8'h12, 8'h25, 8'h07, 12'h123, 1'b1}  // R5 all match
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", 3'(a), 16'h0);
    check("R1 irq", {15'h0, alarm_irq}, 16'h0);

    // R2 / R3 masking
    wr(3'd0, 16'hFFFF); rd("R2", 3'd0, 16'h007F);
    wr(3'd1, 16'hFFFF); rd("R3 sec", 3'd1, 16'h007F);
    wr(3'd2, 16'hFFFF); rd("R3 min", 3'd2, 16'h007F);
    wr(3'd3, 16'hFFFF); rd("R3 hour", 3'd3, 16'h003F);
    wr(3'd4, 16'hFFFF); rd("R3 day", 3'd4, 16'h003F);
    wr(3'd5, 16'hFFFF); rd("R3 mon", 3'd5, 16'h001F);
    wr(3'd6, 16'hFFFF); rd("R3 year", 3'd6, 16'h0FFF);

    // program alarm fields
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0030); wr(3'd2, 16'h0015); wr(3'd3, 16'h0012);
    wr(3'd4, 16'h0025); wr(3'd5, 16'h0007); wr(3'd6, 16'h0123);

    for (int v = 0; v < NV; v++) begin
      {cur_sec, cur_min, cur_hour, cur_mday, cur_mon, cur_year} = VEC[v][52:1];
      wr(3'd0, {9'h0, VEC[v][59:53]});
      check($sformatf("R5 vec%0d pre", v), {15'h0, alarm_irq}, 16'h0);
      tick();
      check($sformatf("R5 vec%0d", v), {15'h0, alarm_irq}, {15'h0, VEC[v][0]});
      wr(3'd7, 16'h0002);
    end

    // R7 matching time without strobe
    {cur_sec, cur_min, cur_hour, cur_mday, cur_mon, cur_year} =
      {8'h30, 8'h15, 8'h12, 8'h25, 8'h07, 12'h123};
    wr(3'd0, 16'h007F);
    repeat (5) @(negedge clk);
    check("R7 no strobe", {15'h0, alarm_irq}, 16'h0);

    // R8 / R9 sticky and clear
    tick();
    check("R8 irq", {15'h0, alarm_irq}, 16'h1);
    rd("R8 pend", 3'd7, 16'h0002);
    repeat (4) @(negedge clk);
    check("R9 sticky", {15'h0, alarm_irq}, 16'h1);
    wr(3'd7, 16'hFFFD);
    check("R9 write0", {15'h0, alarm_irq}, 16'h1);
    wr(3'd7, 16'h0002);
    check("R9 clear", {15'h0, alarm_irq}, 16'h0);
    rd("R9 pend", 3'd7, 16'h0000);

    // R10 fire and clear same cycle
    sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 16'h0002;
    @(negedge clk);
    sec_tick = 1'b0; reg_wr = 1'b0;
    check("R10 set wins", {15'h0, alarm_irq}, 16'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule